// File: doc/BRIEF.md
# Three-Wire Serial Control Port

This block is the control port of a camera analog front-end. A host drives three wires: a serial clock, a serial data line and a load strobe. While the strobe is low, each rising serial clock edge moves one bit of a frame into the block. A frame is made of a read/write flag, a three-bit register select and up to ten data bits. A write frame takes effect on the rising edge of the strobe. In a read frame, the block drives the data line itself once the register select has arrived.

The register file holds the settings of the front-end. The first mode word has five two-bit fields: operating path, output format, clock polarity, power-down state and black clamp level. The other registers are a ten-bit gain word, two eight-bit auxiliary converter codes and a second mode word with three single-bit controls. The serial pins are sampled with the system clock through a synchronizer of `SYNC_STAGES` flops, and edges are detected after it. The data line is split into an input, an output and an output enable. A pad cell outside the block joins them.

Top module: `srif_ctrl`

## Requirements
- R1: Out of reset, the operating-path field reads 2'b11 (the CCD path). Every other register field reads zero, and the data-line enable is low.
- R2: A frame is taken LSB-first on rising serial clock edges while the strobe is low. The order is the read/write flag (0 = write), then select bits A0, A1, A2, then data bits D0 to D9. The select value is A0 + 2·A1 + 4·A2. Value 1 is the first mode word, 2 the gain word, 3 the first converter code, 4 the second converter code and 7 the second mode word. A write frame with all 14 edges loads the selected register on the strobe's rising edge, and no register changes at any other time.
- R3: Rising serial clock edges after the 14th in a frame are ignored. A 16-edge frame with two trailing dummy bits writes the same value as the 14-edge frame.
- R4: A write frame with fewer than 14 edges leaves every register unchanged, except in the case of R5.
- R5: In a 12-edge write frame to the gain word, the 8 data bits go to gain bits 9..2 and gain bits 1..0 are cleared. This applies only when the operating-path field is 2'b01. In any other path, or for any other register, a 12-edge frame writes nothing. A full 14-edge gain write still works when the path field is 2'b01.
- R6: The first mode word maps D1..D0 to the operating path, D3..D2 to the output format, D5..D4 to the clock polarity, D7..D6 to the power-down state and D9..D8 to the clamp level.
- R7: The second mode word maps D0 to even/odd correction disable, D2 to internal gain control select and D3 to converter enable. Bit D1 always reads back as zero, whatever value is written to it.
- R8: A converter code takes D7..D0. D9 and D8 are discarded, and a read returns them as zero.
- R9: In a read frame (flag 1), no register changes. The data-line enable rises with the 4th edge. After edge 4+k the line carries bit k of the selected register. After edge 14 it carries 0.
- R10: Writes to select values 0, 5 and 6 change nothing, and reads from them return zero.
- R11: Every output change occurs on the (SYNC_STAGES+1)-th rising system clock edge after the serial input change that causes it.
- R12: While the strobe is high, the frame is held cleared and serial clock edges are ignored. The data-line enable drops once the strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial wires |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| sload | input | 1 | Load strobe, active low during a frame |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data towards the host during a read |
| sdo_oe | output | 1 | Drive enable for the data line |
| op_mode | output | 2 | Operating path select |
| out_mode | output | 2 | Output format select |
| clk_pol | output | 2 | Sample-clock and clamp-pulse polarity |
| pwr_mode | output | 2 | Power-down state |
| clamp_lvl | output | 2 | Black clamp level select |
| gain | output | DATA_W | Amplifier gain word |
| dac_a | output | DAC_W | First auxiliary converter code |
| dac_b | output | DAC_W | Second auxiliary converter code |
| eo_corr_off | output | 1 | Even/odd offset correction disable |
| gain_int | output | 1 | Gain from the internal register when high |
| dac_en | output | 1 | Auxiliary converter enable |

## Verification
Every result of this block lands exactly SYNC_STAGES+1 system clock edges after its cause: a register after the strobe rise, and the data line after each serial clock rise. The bench applies each change to its own behavioural model on that same edge and compares all outputs on every falling clock edge. A result one cycle early or one cycle late is therefore reported as a mismatch. One directed sequence also samples a register on each cycle after a strobe rise. It expects the old value up to edge SYNC_STAGES and the new value from the next edge on.

// File: rtl/srif_pkg.sv
package srif_pkg;
   // register select values, A0 is the least significant bit
   localparam logic [2:0] SEL_MODE_A = 3'd1;
   localparam logic [2:0] SEL_GAIN   = 3'd2;
   localparam logic [2:0] SEL_DAC_A  = 3'd3;
   localparam logic [2:0] SEL_DAC_B  = 3'd4;
   localparam logic [2:0] SEL_MODE_B = 3'd7;

   // first mode word field positions (two bits each)
   localparam int MA_OPM  = 0;
   localparam int MA_OUTM = 2;
   localparam int MA_CPOL = 4;
   localparam int MA_PWR  = 6;
   localparam int MA_CLMP = 8;

   // second mode word bit positions
   localparam int MB_EO    = 0;
   localparam int MB_GSRC  = 2;
   localparam int MB_DACEN = 3;

   typedef enum logic [1:0] {
      OPM_ADC  = 2'b00,
      OPM_AUX  = 2'b01,
      OPM_CCD  = 2'b10,
      OPM_CCD2 = 2'b11
   } opm_e;

   localparam logic [1:0] OPM_RESET = OPM_CCD2;
endpackage

// File: rtl/srif_sync_edge.sv
module srif_sync_edge #(
   parameter int STAGES = 2,
   parameter bit INIT   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic rise
);
   logic prev;

   if (STAGES == 0) begin : g_direct
      assign level = din;
   end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= {STAGES{INIT}};
         end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
         end
      end
      assign level = chain[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= INIT;
      else        prev <= level;
   end

   assign rise = level & ~prev;

   initial assert (STAGES >= 0 && STAGES <= 4)
      else $fatal(1, "srif_sync_edge: STAGES out of range");
endmodule

// File: rtl/srif_frame.sv
module srif_frame #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 10,
   localparam int HDR_BITS   = 1 + ADDR_W,
   localparam int FRAME_BITS = HDR_BITS + DATA_W,
   localparam int CNT_W      = $clog2(FRAME_BITS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_lvl,
   input  logic              bit_rise,
   input  logic              sdi_lvl,
   output logic [CNT_W-1:0]  cnt,
   output logic              rw,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data
);
   logic room;
   assign room = (cnt != CNT_W'(FRAME_BITS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         rw   <= 1'b0;
         addr <= '0;
         data <= '0;
      end else if (load_lvl) begin
         cnt  <= '0;
         rw   <= 1'b0;
         addr <= '0;
         data <= '0;
      end else if (bit_rise && room) begin
         cnt <= cnt + CNT_W'(1);
         if (cnt == '0) rw <= sdi_lvl;
         for (int i = 0; i < ADDR_W; i++)
            if (cnt == CNT_W'(1 + i)) addr[i] <= sdi_lvl;
         for (int i = 0; i < DATA_W; i++)
            if (cnt == CNT_W'(HDR_BITS + i)) data[i] <= sdi_lvl;
      end
   end

   // edges past a full frame leave the captured frame untouched
   assert_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_lvl && cnt == CNT_W'(FRAME_BITS)) |=> ($stable(data) && $stable(addr) && $stable(rw)));

   // a high strobe holds the frame cleared
   assert_load_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
      load_lvl |=> (cnt == '0));
endmodule

// File: rtl/srif_regfile.sv
module srif_regfile
   import srif_pkg::*;
#(
   parameter int DATA_W  = 10,
   parameter int DAC_W   = 8,
   parameter int SHORT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_short,
   input  logic [2:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [2:0]        rd_sel,
   output logic [DATA_W-1:0] rd_word,
   output logic [1:0]        op_mode,
   output logic [1:0]        out_mode,
   output logic [1:0]        clk_pol,
   output logic [1:0]        pwr_mode,
   output logic [1:0]        clamp_lvl,
   output logic [DATA_W-1:0] gain,
   output logic [DAC_W-1:0]  dac_a,
   output logic [DAC_W-1:0]  dac_b,
   output logic              eo_corr_off,
   output logic              gain_int,
   output logic              dac_en
);
   localparam int PAD_W = DATA_W - SHORT_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_mode     <= OPM_RESET;
         out_mode    <= '0;
         clk_pol     <= '0;
         pwr_mode    <= '0;
         clamp_lvl   <= '0;
         gain        <= '0;
         dac_a       <= '0;
         dac_b       <= '0;
         eo_corr_off <= 1'b0;
         gain_int    <= 1'b0;
         dac_en      <= 1'b0;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_MODE_A: begin
               op_mode   <= wr_data[MA_OPM  +: 2];
               out_mode  <= wr_data[MA_OUTM +: 2];
               clk_pol   <= wr_data[MA_CPOL +: 2];
               pwr_mode  <= wr_data[MA_PWR  +: 2];
               clamp_lvl <= wr_data[MA_CLMP +: 2];
            end
            SEL_GAIN: begin
               if (wr_short) gain <= {wr_data[SHORT_W-1:0], {PAD_W{1'b0}}};
               else          gain <= wr_data;
            end
            SEL_DAC_A:  dac_a <= wr_data[DAC_W-1:0];
            SEL_DAC_B:  dac_b <= wr_data[DAC_W-1:0];
            SEL_MODE_B: begin
               eo_corr_off <= wr_data[MB_EO];
               gain_int    <= wr_data[MB_GSRC];
               dac_en      <= wr_data[MB_DACEN];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      rd_word = '0;
      case (rd_sel)
         SEL_MODE_A: rd_word = DATA_W'({clamp_lvl, pwr_mode, clk_pol, out_mode, op_mode});
         SEL_GAIN:   rd_word = gain;
         SEL_DAC_A:  rd_word = DATA_W'(dac_a);
         SEL_DAC_B:  rd_word = DATA_W'(dac_b);
         SEL_MODE_B: rd_word = DATA_W'({dac_en, gain_int, 1'b0, eo_corr_off});
         default:    rd_word = '0;
      endcase
   end

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(gain) && $stable(dac_a) && $stable(dac_b) && $stable(op_mode)
                  && $stable(out_mode) && $stable(clk_pol) && $stable(pwr_mode)
                  && $stable(clamp_lvl) && $stable(eo_corr_off) && $stable(gain_int)
                  && $stable(dac_en)));

   assert_short_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_short) |=> (gain[PAD_W-1:0] == '0));

   initial assert (SHORT_W < DATA_W && DAC_W <= DATA_W && DATA_W >= 10)
      else $fatal(1, "srif_regfile: width parameters inconsistent");
endmodule

// File: rtl/srif_ctrl.sv
module srif_ctrl
   import srif_pkg::*;
#(
   parameter int ADDR_W      = 3,
   parameter int DATA_W      = 10,
   parameter int DAC_W       = 8,
   parameter int SHORT_W     = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit AUX_SHORT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              sload,
   input  logic              sdi,
   output logic              sdo,
   output logic              sdo_oe,
   output logic [1:0]        op_mode,
   output logic [1:0]        out_mode,
   output logic [1:0]        clk_pol,
   output logic [1:0]        pwr_mode,
   output logic [1:0]        clamp_lvl,
   output logic [DATA_W-1:0] gain,
   output logic [DAC_W-1:0]  dac_a,
   output logic [DAC_W-1:0]  dac_b,
   output logic              eo_corr_off,
   output logic              gain_int,
   output logic              dac_en
);
   localparam int HDR_BITS   = 1 + ADDR_W;
   localparam int FRAME_BITS = HDR_BITS + DATA_W;
   localparam int CNT_W      = $clog2(FRAME_BITS + 1);

   logic              clk_lvl, bit_rise;
   logic              load_lvl, load_rise;
   logic              sdi_lvl, sdi_rise;
   logic [CNT_W-1:0]  cnt;
   logic              rw;
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] data;
   logic [DATA_W-1:0] rd_word;
   logic              full_len, short_ok, wr_en, sdo_bit;

   srif_sync_edge #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sclk (
      .clk(clk), .rst_n(rst_n), .din(sclk), .level(clk_lvl), .rise(bit_rise));
   srif_sync_edge #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sload (
      .clk(clk), .rst_n(rst_n), .din(sload), .level(load_lvl), .rise(load_rise));
   srif_sync_edge #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sdi (
      .clk(clk), .rst_n(rst_n), .din(sdi), .level(sdi_lvl), .rise(sdi_rise));

   srif_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .load_lvl(load_lvl), .bit_rise(bit_rise),
      .sdi_lvl(sdi_lvl), .cnt(cnt), .rw(rw), .addr(addr), .data(data));

   assign full_len = (cnt == CNT_W'(FRAME_BITS));

   if (AUX_SHORT) begin : g_short
      assign short_ok = (cnt == CNT_W'(HDR_BITS + SHORT_W)) &&
                        (op_mode == OPM_AUX) && (addr == SEL_GAIN);
   end else begin : g_no_short
      assign short_ok = 1'b0;
   end

   assign wr_en = load_rise & ~rw & (full_len | short_ok);

   srif_regfile #(.DATA_W(DATA_W), .DAC_W(DAC_W), .SHORT_W(SHORT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_short(short_ok),
      .wr_sel(addr), .wr_data(data), .rd_sel(addr), .rd_word(rd_word),
      .op_mode(op_mode), .out_mode(out_mode), .clk_pol(clk_pol),
      .pwr_mode(pwr_mode), .clamp_lvl(clamp_lvl), .gain(gain),
      .dac_a(dac_a), .dac_b(dac_b), .eo_corr_off(eo_corr_off),
      .gain_int(gain_int), .dac_en(dac_en));

   // read path: bit k after header edge count HDR_BITS+k
   always_comb begin
      sdo_bit = 1'b0;
      for (int i = 0; i < DATA_W; i++)
         if (cnt == CNT_W'(HDR_BITS + i)) sdo_bit = rd_word[i];
   end

   assign sdo_oe = rw & (cnt >= CNT_W'(HDR_BITS));
   assign sdo    = sdo_oe & sdo_bit;

   assert_oe_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdo_oe) |-> $past(bit_rise));

   assert_oe_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(load_lvl) |=> !sdo_oe);

   initial assert (ADDR_W == 3 && SYNC_STAGES >= 0 && clk_lvl == clk_lvl && sdi_rise == sdi_rise)
      else $fatal(1, "srif_ctrl: parameter check failed");
endmodule

// File: tb/sim_srif_ctrl.sv
module sim_srif_ctrl;
   localparam int SYNC = 2;
   localparam int L    = SYNC + 1;

   logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, sload = 1'b1, sdi = 1'b0;
   logic sdo, sdo_oe, eo_corr_off, gain_int, dac_en;
   logic [1:0] op_mode, out_mode, clk_pol, pwr_mode, clamp_lvl;
   logic [9:0] gain;
   logic [7:0] dac_a, dac_b;

   always #5 clk = ~clk;

   srif_ctrl #(.SYNC_STAGES(SYNC)) u0 (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .sload(sload), .sdi(sdi),
      .sdo(sdo), .sdo_oe(sdo_oe), .op_mode(op_mode), .out_mode(out_mode),
      .clk_pol(clk_pol), .pwr_mode(pwr_mode), .clamp_lvl(clamp_lvl),
      .gain(gain), .dac_a(dac_a), .dac_b(dac_b), .eo_corr_off(eo_corr_off),
      .gain_int(gain_int), .dac_en(dac_en));

   int m_op, m_out, m_pol, m_pwr, m_clamp, m_gain, m_da, m_db, m_eo, m_gi, m_de;
   int m_cnt, m_rw, m_sel;
   logic [9:0] m_d;
   bit m_load = 1'b1;
   bit cmp_on = 1'b0;
   bit done = 1'b0;
   string phase = "init";
   int n_cmp = 0, n_bad = 0;

   function automatic int rd_word(int s);
      case (s)
         1: return (m_clamp << 8) | (m_pwr << 6) | (m_pol << 4) | (m_out << 2) | m_op;
         2: return m_gain;
         3: return m_da;
         4: return m_db;
         7: return (m_de << 3) | (m_gi << 2) | m_eo;
         default: return 0;
      endcase
   endfunction

   function automatic void model_reset();
      m_op = 3; m_out = 0; m_pol = 0; m_pwr = 0; m_clamp = 0;
      m_gain = 0; m_da = 0; m_db = 0; m_eo = 0; m_gi = 0; m_de = 0;
      m_cnt = 0; m_rw = 0; m_sel = 0; m_d = '0;
   endfunction

   function automatic void model_edge(bit b);
      if (m_cnt < 14) begin
         if (m_cnt == 0) m_rw = b;
         else if (m_cnt <= 3) m_sel = m_sel | (int'(b) << (m_cnt - 1));
         else m_d[m_cnt-4] = b;
         m_cnt++;
      end
   endfunction

   function automatic void model_load_rise();
      bit full, short;
      full  = (m_cnt == 14);
      short = (m_cnt == 12) && (m_op == 1) && (m_sel == 2);
      if (m_rw == 0 && (full || short)) begin
         case (m_sel)
            1: begin
               m_op = m_d[1:0]; m_out = m_d[3:2]; m_pol = m_d[5:4];
               m_pwr = m_d[7:6]; m_clamp = m_d[9:8];
            end
            2: m_gain = short ? (int'(m_d[7:0]) * 4) : int'(m_d);
            3: m_da = m_d[7:0];
            4: m_db = m_d[7:0];
            7: begin m_eo = m_d[0]; m_gi = m_d[2]; m_de = m_d[3]; end
            default: ;
         endcase
      end
      m_cnt = 0; m_rw = 0; m_sel = 0; m_d = '0;
   endfunction

   task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s [%s] actual %h expected %h at %0t", tag, phase, got, exp, $time);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (cmp_on) begin
         int exp_oe, exp_sdo;
         exp_oe  = (m_rw == 1 && m_cnt >= 4) ? 1 : 0;
         exp_sdo = (exp_oe == 1 && m_cnt < 14) ? ((rd_word(m_sel) >> (m_cnt - 4)) & 1) : 0;
         check("R6 op_mode",     16'(op_mode),     16'(m_op));
         check("R6 out_mode",    16'(out_mode),    16'(m_out));
         check("R6 clk_pol",     16'(clk_pol),     16'(m_pol));
         check("R6 pwr_mode",    16'(pwr_mode),    16'(m_pwr));
         check("R6 clamp_lvl",   16'(clamp_lvl),   16'(m_clamp));
         check("R2 gain",        16'(gain),        16'(m_gain));
         check("R8 dac_a",       16'(dac_a),       16'(m_da));
         check("R8 dac_b",       16'(dac_b),       16'(m_db));
         check("R7 eo_corr_off", 16'(eo_corr_off), 16'(m_eo));
         check("R7 gain_int",    16'(gain_int),    16'(m_gi));
         check("R7 dac_en",      16'(dac_en),      16'(m_de));
         check("R9 sdo_oe",      16'(sdo_oe),      16'(exp_oe));
         check("R9 sdo",         16'(sdo),         16'(exp_sdo));
      end
   end

   task automatic edge_bit(bit b);
      @(negedge clk) sdi = b;
      @(negedge clk) sclk = 1'b1;
      repeat (L) @(posedge clk);
      if (!m_load) model_edge(b);
      @(negedge clk);
      @(negedge clk) sclk = 1'b0;
      @(negedge clk);
   endtask

   task automatic load_to(bit v);
      @(negedge clk) sload = v;
      repeat (L) @(posedge clk);
      if (v && !m_load) model_load_rise();
      m_load = v;
      @(negedge clk);
   endtask

   task automatic send(bit rw, int sel, logic [9:0] d, int nd, int extra);
      load_to(1'b0);
      edge_bit(rw);
      for (int a = 0; a < 3; a++) edge_bit(sel[a]);
      for (int i = 0; i < nd; i++) edge_bit(d[i]);
      for (int e = 0; e < extra; e++) edge_bit(1'b1);
      load_to(1'b1);
      repeat (3) @(negedge clk);
   endtask

   task automatic read_reg(int sel, logic [15:0] exp, string tag);
      logic [15:0] word;
      word = '0;
      load_to(1'b0);
      edge_bit(1'b1);
      for (int a = 0; a < 3; a++) edge_bit(sel[a]);
      for (int i = 0; i < 10; i++) begin
         word[i] = sdo;
         edge_bit(1'b0);
      end
      check({tag, " sdo after edge 14"}, 16'(sdo), 16'h0);
      load_to(1'b1);
      check({tag, " enable released"}, 16'(sdo_oe), 16'h0);
      check(tag, word, exp);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired, run did not complete");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      phase = "R1 reset";
      check("R1 op_mode reset",   16'(op_mode), 16'h3);
      check("R1 gain reset",      16'(gain), 16'h0);
      check("R1 dac_a reset",     16'(dac_a), 16'h0);
      check("R1 mode fields",     16'({out_mode, clk_pol, pwr_mode, clamp_lvl}), 16'h0);
      check("R1 mode_b bits",     16'({eo_corr_off, gain_int, dac_en}), 16'h0);
      check("R1 enable reset",    16'(sdo_oe), 16'h0);
      cmp_on = 1'b1;

      phase = "R2 R6 writes";
      send(1'b0, 1, 10'h326, 10, 0);
      check("R6 fields", 16'({clamp_lvl, pwr_mode, clk_pol, out_mode, op_mode}), 16'h326);
      check("R6 op_mode", 16'(op_mode), 16'h2);
      send(1'b0, 2, 10'h3A5, 10, 0);
      check("R2 gain write", 16'(gain), 16'h3A5);
      phase = "R8 converter codes";
      send(1'b0, 3, 10'h3C7, 10, 0);
      check("R8 dac_a drops D9 D8", 16'(dac_a), 16'h0C7);
      send(1'b0, 4, 10'h15A, 10, 0);
      check("R8 dac_b", 16'(dac_b), 16'h05A);

      phase = "R7 mode_b";
      send(1'b0, 7, 10'h3FF, 10, 0);
      check("R7 mode_b bits", 16'({eo_corr_off, gain_int, dac_en}), 16'h7);
      read_reg(7, 16'h00D, "R7 D1 reads zero");
      send(1'b0, 7, 10'h002, 10, 0);
      read_reg(7, 16'h000, "R7 D1 write ignored");

      phase = "R9 reads";
      read_reg(1, 16'h326, "R9 read mode_a");
      read_reg(2, 16'h3A5, "R9 read gain");
      read_reg(3, 16'h0C7, "R9 read dac_a");
      check("R9 read left gain", 16'(gain), 16'h3A5);

      phase = "R10 unmapped";
      send(1'b0, 0, 10'h3FF, 10, 0);
      send(1'b0, 5, 10'h3FF, 10, 0);
      send(1'b0, 6, 10'h3FF, 10, 0);
      check("R10 gain kept", 16'(gain), 16'h3A5);
      check("R10 dac_a kept", 16'(dac_a), 16'h0C7);
      check("R10 op_mode kept", 16'(op_mode), 16'h2);
      read_reg(6, 16'h000, "R10 read unmapped");
      read_reg(5, 16'h000, "R10 read unmapped 5");

      phase = "R3 extra edges";
      send(1'b0, 4, 10'h0A3, 10, 2);
      check("R3 16-edge dac_b", 16'(dac_b), 16'h0A3);
      send(1'b0, 2, 10'h155, 10, 2);
      check("R3 16-edge gain", 16'(gain), 16'h155);

      phase = "R4 short frames";
      send(1'b0, 3, 10'h011, 9, 0);
      check("R4 13-edge ignored", 16'(dac_a), 16'h0C7);
      send(1'b0, 2, 10'h0B6, 8, 0);
      check("R4 R5 12-edge gain outside aux", 16'(gain), 16'h155);

      phase = "R5 aux short gain";
      send(1'b0, 1, 10'h325, 10, 0);
      check("R5 aux path set", 16'(op_mode), 16'h1);
      send(1'b0, 2, 10'h0B6, 8, 0);
      check("R5 short gain", 16'(gain), 16'h2D8);
      send(1'b0, 3, 10'h022, 8, 0);
      check("R5 short dac ignored", 16'(dac_a), 16'h0C7);
      send(1'b0, 2, 10'h201, 10, 0);
      check("R5 full gain in aux", 16'(gain), 16'h201);

      phase = "R12 strobe high";
      load_to(1'b0);
      edge_bit(1'b0); edge_bit(1'b1); edge_bit(1'b1);
      load_to(1'b1);
      for (int k = 0; k < 3; k++) edge_bit(1'b1);
      send(1'b0, 4, 10'h03C, 10, 0);
      check("R12 clean frame after abort", 16'(dac_b), 16'h03C);
      check("R12 dac_a untouched", 16'(dac_a), 16'h0C7);

      phase = "R11 latency";
      load_to(1'b0);
      edge_bit(1'b0);
      edge_bit(1'b0); edge_bit(1'b0); edge_bit(1'b1);
      for (int i = 0; i < 10; i++) edge_bit(10'h077 >> i);
      @(negedge clk) sload = 1'b1;
      for (int k = 1; k <= L; k++) begin
         @(posedge clk);
         if (k == L) begin
            model_load_rise();
            m_load = 1'b1;
         end
         @(negedge clk);
         check("R11 dac_b edge timing", 16'(dac_b), (k < L) ? 16'h03C : 16'h077);
      end
      repeat (5) @(negedge clk);

      done = 1'b1;
      cmp_on = 1'b0;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule